// File: doc/BRIEF.md
# Receive Frame Queue Classifier

This block steers each received Ethernet frame to one of up to sixteen hardware receive queues. Software programs a small bank of screening rules and a table of EtherType values through a simple register port. Each rule can require a given VLAN priority, a match against one selected EtherType table value, and up to three comparator results. Each comparator result is picked by index from a vector of match flags that an upstream header parser provides.

At frame start the block freezes a working copy of the programmed rules. A parser then presents the header fields and comparator flags with a single "header complete" strobe. One cycle later the block reports the chosen queue with a one-cycle valid pulse. The rule with the smallest number whose enabled conditions all hold supplies the queue. If no rule matches, queue 0 is used. The result stays on the output until the next frame begins.

Top module: `rx_screen_classifier`

## Requirements
- R1: After reset, `q_valid` is 0, `q_num` is 0, and every rule and EtherType register reads back as zero.
- R2: A rule word has this layout: queue in bits 3:0, VLAN priority in bits 6:4, VLAN check enable in bit 8, EtherType table index in bits 11:9, EtherType check enable in bit 12. Comparator index A is in bits 17:13 with its enable in bit 18. Comparator index B is in bits 23:19 with its enable in bit 24. Comparator index C is in bits 29:25 with its enable in bit 30. A rule at address 0..7 reads back exactly as written.
- R3: A rule matches only when every check it enables holds. The VLAN check holds when `frm_pcp` equals the rule's priority. The EtherType check holds when `frm_etype` equals the selected table value. A comparator check holds when bit `index` of `cmp_hit` is 1.
- R4: A rule with no check enabled, such as an all-zero word, never matches.
- R5: When several rules match, the lowest-numbered one supplies the queue. When none matches, the queue is 0.
- R6: A comparator index at or above the comparator count (24) never satisfies its check.
- R7: `q_valid` pulses for one cycle, one clock after the first `hdr_valid` that follows `frm_start`. Any later `hdr_valid` in the same frame is ignored. So is an `hdr_valid` outside a frame, and one in the same cycle as `frm_start`.
- R8: `q_num` holds its value until the next `frm_start`, which returns it to 0.
- R9: A register write changes classification only from the next frame on. A write in the same cycle as `frm_start` is not seen by that frame.
- R10: Address 16 is a read-only resource word. It reads `0x00080818`: 0 in bits 31:24, 8 rules in bits 23:16, 8 EtherType registers in bits 15:8, and 24 comparators in bits 7:0. Writes to it are ignored.
- R11: EtherType registers at addresses 8..15 keep only the low 16 bits of a write. Their upper 16 bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (rules, EtherType table, resource word) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the programmed value at `reg_addr` |
| frm_start | input | 1 | First-cycle strobe of a received frame |
| hdr_valid | input | 1 | Header fields and comparator flags are final |
| frm_etype | input | 16 | EtherType of the frame |
| frm_pcp | input | 3 | VLAN priority of the frame |
| cmp_hit | input | 24 | Per-comparator match flags from the parser |
| q_valid | output | 1 | One-cycle pulse: classification result ready |
| q_num | output | 4 | Selected receive queue |

## Verification
A register write and a frame start can fall in the same cycle. The rule update must then be kept out of the frame that is starting, and must be in force for the frame after it. The bench provokes this collision twice. First it writes a new rule between frame start and header completion. Then it writes a rule in the very cycle of `frm_start`. In both cases it judges the queue reported for the current frame against the old rule set and the queue of the following frame against the new one. A second collision, `hdr_valid` in the frame-start cycle, is judged by the absence of `q_valid` until a later header strobe.

// File: rtl/scr_pkg.sv
package scr_pkg;
   localparam int WORD_W = 32;
   localparam int ETY_W  = 16;
   localparam int QID_W  = 4;
   localparam int PCP_W  = 3;
   localparam int CIX_W  = 5;
   localparam int EIX_W  = 3;

   typedef struct packed {
      logic             rsv31;
      logic             c_en;
      logic [CIX_W-1:0] c_idx;
      logic             b_en;
      logic [CIX_W-1:0] b_idx;
      logic             a_en;
      logic [CIX_W-1:0] a_idx;
      logic             ety_en;
      logic [EIX_W-1:0] ety_idx;
      logic             pcp_en;
      logic             rsv7;
      logic [PCP_W-1:0] pcp;
      logic [QID_W-1:0] queue;
   } rule_t;
endpackage

// File: rtl/scr_regbank.sv
module scr_regbank
   import scr_pkg::*;
#(
   parameter int N_RULE = 8,
   parameter int N_ETY  = 8,
   parameter int N_CMP  = 24,
   parameter int ADDR_W = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_we,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [WORD_W-1:0]           reg_wdata,
   output logic [WORD_W-1:0]           reg_rdata,
   input  logic                        frm_start,
   output logic [N_RULE-1:0][WORD_W-1:0] act_rule,
   output logic [N_ETY-1:0][ETY_W-1:0]   act_ety
);
   localparam int ETY_BASE = N_RULE;
   localparam int CFG_ADDR = N_RULE + N_ETY;
   localparam logic [WORD_W-1:0] CFG_WORD = {8'd0, 8'(N_RULE), 8'(N_ETY), 8'(N_CMP)};

   if (CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("scr_regbank: address space too small");
   end

   logic [N_RULE-1:0][WORD_W-1:0] prog_rule;
   logic [N_ETY-1:0][ETY_W-1:0]   prog_ety;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_rule <= '0;
         prog_ety  <= '0;
         act_rule  <= '0;
         act_ety   <= '0;
      end else begin
         if (frm_start) begin
            act_rule <= prog_rule;
            act_ety  <= prog_ety;
         end
         if (reg_we) begin
            for (int i = 0; i < N_RULE; i++)
               if (reg_addr == ADDR_W'(i)) prog_rule[i] <= reg_wdata;
            for (int j = 0; j < N_ETY; j++)
               if (reg_addr == ADDR_W'(ETY_BASE + j)) prog_ety[j] <= reg_wdata[ETY_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < N_RULE; i++)
         if (reg_addr == ADDR_W'(i)) reg_rdata = prog_rule[i];
      for (int j = 0; j < N_ETY; j++)
         if (reg_addr == ADDR_W'(ETY_BASE + j)) reg_rdata = {{(WORD_W-ETY_W){1'b0}}, prog_ety[j]};
      if (reg_addr == ADDR_W'(CFG_ADDR)) reg_rdata = CFG_WORD;
   end

   AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_start |=> ($stable(act_rule) && $stable(act_ety))); // R9
endmodule

// File: rtl/scr_rule_match.sv
module scr_rule_match
   import scr_pkg::*;
#(
   parameter int N_ETY = 8,
   parameter int N_CMP = 24
) (
   input  logic [WORD_W-1:0]           rule_word,
   input  logic [N_ETY-1:0][ETY_W-1:0] ety_tab,
   input  logic [ETY_W-1:0]            frm_etype,
   input  logic [PCP_W-1:0]            frm_pcp,
   input  logic [N_CMP-1:0]            cmp_hit,
   output logic                        hit
);
   localparam int CMP_SLOTS = 1 << CIX_W;

   rule_t                rule;
   logic [CMP_SLOTS-1:0] hit_pad;
   logic                 ety_ok, pcp_ok, a_ok, b_ok, c_ok, any_en;

   assign rule    = rule_t'(rule_word);
   assign hit_pad = CMP_SLOTS'(cmp_hit);

   always_comb begin
      ety_ok = 1'b0;
      for (int k = 0; k < N_ETY; k++)
         if (rule.ety_idx == EIX_W'(k) && ety_tab[k] == frm_etype) ety_ok = 1'b1;
   end

   assign pcp_ok = (rule.pcp == frm_pcp);
   assign a_ok   = hit_pad[rule.a_idx];
   assign b_ok   = hit_pad[rule.b_idx];
   assign c_ok   = hit_pad[rule.c_idx];
   assign any_en = rule.pcp_en | rule.ety_en | rule.a_en | rule.b_en | rule.c_en;
   assign hit    = any_en
                 & (~rule.pcp_en | pcp_ok)
                 & (~rule.ety_en | ety_ok)
                 & (~rule.a_en   | a_ok)
                 & (~rule.b_en   | b_ok)
                 & (~rule.c_en   | c_ok);
endmodule

// File: rtl/scr_prio_pick.sv
module scr_prio_pick
   import scr_pkg::*;
#(
   parameter int N_RULE = 8
) (
   input  logic [N_RULE-1:0]             hit,
   input  logic [N_RULE-1:0][WORD_W-1:0] act_rule,
   output logic [QID_W-1:0]              queue
);
   logic [N_RULE-1:0] grant;

   assign grant = hit & (~hit + N_RULE'(1));

   always_comb begin
      queue = '0;
      for (int i = 0; i < N_RULE; i++)
         if (grant[i]) queue = act_rule[i][QID_W-1:0];
   end
endmodule

// File: rtl/rx_screen_classifier.sv
module rx_screen_classifier
   import scr_pkg::*;
#(
   parameter int N_RULE = 8,
   parameter int N_ETY  = 8,
   parameter int N_CMP  = 24,
   parameter int ADDR_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               frm_start,
   input  logic               hdr_valid,
   input  logic [15:0]        frm_etype,
   input  logic [2:0]         frm_pcp,
   input  logic [N_CMP-1:0]   cmp_hit,
   output logic               q_valid,
   output logic [3:0]         q_num
);
   if (N_CMP > (1 << CIX_W) || N_CMP > 255) begin : g_bad_cmp
      $error("rx_screen_classifier: comparator count exceeds index range");
   end
   if (N_ETY > (1 << EIX_W) || N_ETY < 1) begin : g_bad_ety
      $error("rx_screen_classifier: EtherType table size out of range");
   end
   if (N_RULE < 1 || N_RULE > 255) begin : g_bad_rule
      $error("rx_screen_classifier: rule count out of range");
   end

   logic [N_RULE-1:0][WORD_W-1:0] act_rule;
   logic [N_ETY-1:0][ETY_W-1:0]   act_ety;
   logic [N_RULE-1:0]             rule_hit;
   logic [QID_W-1:0]              pick_q;
   logic                          in_frame, classify;

   scr_regbank #(.N_RULE(N_RULE), .N_ETY(N_ETY), .N_CMP(N_CMP), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_start(frm_start),
      .act_rule(act_rule), .act_ety(act_ety)
   );

   for (genvar g = 0; g < N_RULE; g++) begin : g_rule
      scr_rule_match #(.N_ETY(N_ETY), .N_CMP(N_CMP)) u_match (
         .rule_word(act_rule[g]), .ety_tab(act_ety), .frm_etype(frm_etype),
         .frm_pcp(frm_pcp), .cmp_hit(cmp_hit), .hit(rule_hit[g])
      );
   end

   scr_prio_pick #(.N_RULE(N_RULE)) u_pick (
      .hit(rule_hit), .act_rule(act_rule), .queue(pick_q)
   );

   assign classify = hdr_valid & in_frame & ~frm_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         q_valid  <= 1'b0;
         q_num    <= '0;
      end else if (frm_start) begin
         in_frame <= 1'b1;
         q_valid  <= 1'b0;
         q_num    <= '0;
      end else if (classify) begin
         in_frame <= 1'b0;
         q_valid  <= 1'b1;
         q_num    <= pick_q;
      end else begin
         q_valid  <= 1'b0;
      end
   end

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> !q_valid); // R7
   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> ($past(hdr_valid) && !$past(frm_start))); // R7
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!frm_start && !hdr_valid) |=> $stable(q_num)); // R8
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |=> (q_num == '0 && !q_valid)); // R8
   AST_NO_HIT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (classify && rule_hit == '0) |=> (q_num == '0)); // R5
endmodule

// File: tb/sim_rx_screen_classifier.sv
`timescale 1ns/1ps
module sim_rx_screen_classifier;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        frm_start = 1'b0;
   logic        hdr_valid = 1'b0;
   logic [15:0] frm_etype = '0;
   logic [2:0]  frm_pcp = '0;
   logic [23:0] cmp_hit = '0;
   logic        q_valid;
   logic [3:0]  q_num;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   rx_screen_classifier u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_start(frm_start),
      .hdr_valid(hdr_valid), .frm_etype(frm_etype), .frm_pcp(frm_pcp),
      .cmp_hit(cmp_hit), .q_valid(q_valid), .q_num(q_num)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic start_frame();
      @(negedge clk);
      frm_start = 1'b1;
      @(negedge clk);
      frm_start = 1'b0;
   endtask

   // header strobe; result is registered at the next edge, sampled at the following negedge
   task automatic hdr_chk(input string tag, input logic [15:0] ety, input logic [2:0] pcp,
                          input logic [23:0] hits, input logic exp_v, input logic [3:0] exp_q);
      frm_etype = ety; frm_pcp = pcp; cmp_hit = hits; hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk({tag, " valid"}, 32'(q_valid), 32'(exp_v));
      if (exp_v) chk({tag, " queue"}, 32'(q_num), 32'(exp_q));
   endtask

   task automatic classify(input string tag, input logic [15:0] ety, input logic [2:0] pcp,
                           input logic [23:0] hits, input logic [3:0] exp_q);
      start_frame();
      hdr_chk(tag, ety, pcp, hits, 1'b1, exp_q);
   endtask

   task automatic t_reset();
      chk("R1 q_valid", 32'(q_valid), 32'd0);
      chk("R1 q_num", 32'(q_num), 32'd0);
      rd_chk("R1 rule0", 5'd0, 32'd0);
      rd_chk("R1 ety7", 5'd15, 32'd0);
   endtask

   task automatic t_regs();
      wr(5'd3, 32'hDEADBEEF);
      rd_chk("R2 rule readback", 5'd3, 32'hDEADBEEF);
      wr(5'd9, 32'h1234_86DD);
      rd_chk("R11 ety low half", 5'd9, 32'h0000_86DD);
      rd_chk("R10 resource word", 5'd16, 32'h0008_0818);
      wr(5'd16, 32'hFFFF_FFFF);
      rd_chk("R10 write ignored", 5'd16, 32'h0008_0818);
      wr(5'd3, 32'd0);
   endtask

   task automatic t_all_zero();
      classify("R4 zero rules", 16'h0000, 3'd0, 24'h000000, 4'd0);
      classify("R4 zero rules all hits", 16'h0000, 3'd0, 24'hFFFFFF, 4'd0);
   endtask

   task automatic t_program();
      wr(5'd8, 32'h0000_0800);       // ety0 = IPv4
      wr(5'd1, 32'h0004_B005);       // q5: ety idx0 + cmp A idx5
      wr(5'd2, 32'h0000_0137);       // q7: pcp 3
      wr(5'd4, 32'h01F0_0009);       // q9: cmp B idx30 (out of range)
      wr(5'd5, 32'h6E00_1203);       // q3: ety idx1 + cmp C idx23
   endtask

   task automatic t_match();
      classify("R3 ety+cmpA", 16'h0800, 3'd0, 24'h000020, 4'd5);
      classify("R3 cmpA missing -> pcp rule", 16'h0800, 3'd3, 24'h000000, 4'd7);
      classify("R5 lowest wins", 16'h0800, 3'd3, 24'h000020, 4'd5);
      classify("R5 no match", 16'h0800, 3'd0, 24'h000000, 4'd0);
      classify("R3 ety+cmpC", 16'h86DD, 3'd0, 24'h800000, 4'd3);
      classify("R3 cmpC missing", 16'h86DD, 3'd0, 24'h7FFFFF, 4'd0);
      classify("R6 index beyond count", 16'h1234, 3'd0, 24'hFFFFFF, 4'd0);
   endtask

   task automatic t_once();
      classify("R7 first header", 16'h0800, 3'd0, 24'h000020, 4'd5);
      @(negedge clk);
      chk("R7 pulse ends", 32'(q_valid), 32'd0);
      hdr_chk("R7 second header ignored", 16'h0800, 3'd3, 24'h0, 1'b0, 4'd0);
      repeat (3) @(negedge clk);
      chk("R8 queue held", 32'(q_num), 32'd5);
      @(negedge clk);
      frm_start = 1'b1; hdr_valid = 1'b1; frm_pcp = 3'd3; cmp_hit = '0;
      @(negedge clk);
      frm_start = 1'b0; hdr_valid = 1'b0;
      chk("R8 start clears queue", 32'(q_num), 32'd0);
      chk("R7 header with start ignored", 32'(q_valid), 32'd0);
      hdr_chk("R7 later header accepted", 16'h0800, 3'd3, 24'h0, 1'b1, 4'd7);
   endtask

   task automatic t_outside();
      @(negedge clk);
      hdr_chk("R7 header outside frame", 16'h0800, 3'd3, 24'h0, 1'b0, 4'd0);
   endtask

   task automatic t_write_timing();
      start_frame();
      wr(5'd0, 32'h0000_011B);       // q11: pcp 1
      hdr_chk("R9 mid-frame write unused", 16'h1234, 3'd1, 24'h0, 1'b1, 4'd0);
      classify("R9 write used next frame", 16'h1234, 3'd1, 24'h0, 4'd11);
      @(negedge clk);
      frm_start = 1'b1; reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = 32'd0;
      @(negedge clk);
      frm_start = 1'b0; reg_we = 1'b0;
      hdr_chk("R9 write at start unused", 16'h1234, 3'd1, 24'h0, 1'b1, 4'd11);
      classify("R9 start-cycle write next frame", 16'h1234, 3'd1, 24'h0, 4'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_all_zero();
      t_program();
      t_match();
      t_once();
      t_outside();
      t_write_timing();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule